// File: doc/BRIEF.md
# Vector Compare-Immediate Sequencer with Data-Dependent Early Exit

The block steps a signed compare-immediate across a run of register elements, one element per clock. Each step reads one source element from an internal register file and emits a 3-bit condition field on a write port, for a condition array that lies outside the block. A selectable test is applied to each new field. When that test reports a failure, the run stops at once and the vector length is cut at the failing element. The cut is inclusive or exclusive as selected. In exclusive mode the length can drop to zero.

Source and destination each advance by one element per step only when their vectorised flag is set. Otherwise the same scalar register, or the same condition slot, is used on every step. Software loads the register file through a plain write port. It then pulses `start_i` with the run parameters, collects the condition writes, and reads the resulting vector length on the cycle `done_o` is high.

Top module: `vcmp_ddff`

## Requirements
- R1: After reset `cr_we_o` and `done_o` are 0 and `vl_o` is 0.
- R2: An accepted start with VL>0 produces one condition write per element, on consecutive cycles, beginning the cycle after the start. Each field is a signed compare of the source element against the sign-extended immediate, with bit 2 = less-than, bit 1 = greater-than and bit 0 = equal. Exactly one bit is set.
- R3: The condition index of element i is `dst_base_i + i` modulo the array size when `dst_vec_i` was set at start. Otherwise it is `dst_base_i` for every element.
- R4: The source register of element i is `src_base_i + i` modulo the register count when `src_vec_i` was set at start. Otherwise it is `src_base_i` for every element.
- R5: The fail test selects a field bit with `test_sel_i` (0 = equal, 1 = greater-than, 2 = less-than). An element fails when that bit XOR `test_inv_i` is 1. With `test_sel_i` = 3 no element ever fails.
- R6: In inclusive mode (`incl_i`=1), a failure at element i writes that element's field, issues no further writes, and reports `vl_o` = i+1.
- R7: In exclusive mode (`incl_i`=0), a failure at element i still writes that element's field, issues no further writes, and reports `vl_o` = i. A failure at element 0 gives 0.
- R8: If no element fails, `vl_o` equals the VL given at start.
- R9: `done_o` is high for exactly one cycle, the cycle after the last condition write. With VL=0 it is high the cycle after the start, with no writes and `vl_o`=0.
- R10: `start_i` is ignored while a run is in progress or while `done_o` is high.
- R11: A register-file write is visible to compares from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_we_i | input | 1 | Register file write enable |
| rf_waddr_i | input | AW (3) | Register file write index |
| rf_wdata_i | input | XLEN (16) | Register file write data |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | VLW (4) | Requested vector length |
| src_base_i | input | AW (3) | First source register |
| dst_base_i | input | CW (3) | First condition slot |
| src_vec_i | input | 1 | Source advances per element |
| dst_vec_i | input | 1 | Destination advances per element |
| imm_i | input | IMMW (8) | Signed immediate |
| incl_i | input | 1 | 1 = inclusive cut, 0 = exclusive cut |
| test_sel_i | input | 2 | Field bit tested (3 = no test) |
| test_inv_i | input | 1 | Invert the tested bit |
| cr_we_o | output | 1 | Condition write strobe |
| cr_idx_o | output | CW (3) | Condition slot written |
| cr_field_o | output | 3 | Condition field {lt, gt, eq} |
| done_o | output | 1 | Run finished, one cycle |
| vl_o | output | VLW (4) | Resulting vector length |

## Verification
The bench aims at a failure on the very first element in exclusive mode. A design that cut off by one there would report 1 instead of 0, or would drop the failing field's write. Runs that never fail catch a design that truncates anyway, or that stops a step early at the last element. Scalar operands and base indices near the top of the register space catch pointers that advance when they should not, or that fail to wrap. Start pulses held through a whole run catch a sequencer that restarts, or that extends its write stream.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cr_field_t;

  typedef enum logic [1:0] {
    SEL_EQ   = 2'd0,
    SEL_GT   = 2'd1,
    SEL_LT   = 2'd2,
    SEL_NONE = 2'd3
  } test_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vcmp_regfile.sv
module vcmp_regfile #(
  parameter int XLEN  = 16,
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREGS; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/vcmp_compare.sv
module vcmp_compare
  import vcmp_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int IMMW = 8
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [1:0]      sel_i,
  input  logic            inv_i,
  output cr_field_t       field_o,
  output logic            fail_o
);
  logic signed [XLEN-1:0] src_s;
  logic signed [XLEN-1:0] imm_ext;
  test_sel_e              sel;

  assign src_s   = $signed(src_i);
  assign imm_ext = XLEN'($signed(imm_i));
  assign sel     = test_sel_e'(sel_i);

  always_comb begin
    field_o.lt = src_s < imm_ext;
    field_o.gt = src_s > imm_ext;
    field_o.eq = src_s == imm_ext;
  end

  always_comb begin
    unique case (sel)
      SEL_EQ:  fail_o = field_o.eq ^ inv_i;
      SEL_GT:  fail_o = field_o.gt ^ inv_i;
      SEL_LT:  fail_o = field_o.lt ^ inv_i;
      default: fail_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq
  import vcmp_pkg::*;
#(
  parameter int AW   = 3,
  parameter int CW   = 3,
  parameter int VLW  = 4,
  parameter int IMMW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [AW-1:0]   src_base_i,
  input  logic [CW-1:0]   dst_base_i,
  input  logic            src_vec_i,
  input  logic            dst_vec_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            incl_i,
  input  logic [1:0]      sel_i,
  input  logic            inv_i,
  input  logic            fail_i,
  output logic            run_o,
  output logic            done_o,
  output logic [AW-1:0]   src_ptr_o,
  output logic [CW-1:0]   dst_ptr_o,
  output logic [IMMW-1:0] imm_o,
  output logic [1:0]      sel_o,
  output logic            inv_o,
  output logic            dvec_o,
  output logic [VLW-1:0]  vl_cap_o,
  output logic [VLW-1:0]  vl_o
);
  seq_state_e     state_q;
  logic [VLW-1:0] idx_q, vl_q, vl_res_q;
  logic [AW-1:0]  sp_q;
  logic [CW-1:0]  dp_q;
  logic           svec_q, dvec_q, incl_q, inv_q;
  logic [1:0]     sel_q;
  logic [IMMW-1:0] imm_q;
  logic           last;

  assign last = (idx_q + VLW'(1)) == vl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      vl_q     <= '0;
      vl_res_q <= '0;
      sp_q     <= '0;
      dp_q     <= '0;
      svec_q   <= 1'b0;
      dvec_q   <= 1'b0;
      incl_q   <= 1'b0;
      inv_q    <= 1'b0;
      sel_q    <= '0;
      imm_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q  <= '0;
          vl_q   <= vl_i;
          sp_q   <= src_base_i;
          dp_q   <= dst_base_i;
          svec_q <= src_vec_i;
          dvec_q <= dst_vec_i;
          incl_q <= incl_i;
          inv_q  <= inv_i;
          sel_q  <= sel_i;
          imm_q  <= imm_i;
          if (vl_i == '0) begin
            vl_res_q <= '0;
            state_q  <= ST_DONE;
          end else begin
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fail_i) begin
            vl_res_q <= incl_q ? idx_q + VLW'(1) : idx_q;
            state_q  <= ST_DONE;
          end else if (last) begin
            vl_res_q <= vl_q;
            state_q  <= ST_DONE;
          end else begin
            idx_q <= idx_q + VLW'(1);
            sp_q  <= sp_q + AW'(svec_q);
            dp_q  <= dp_q + CW'(dvec_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o     = state_q == ST_RUN;
  assign done_o    = state_q == ST_DONE;
  assign src_ptr_o = sp_q;
  assign dst_ptr_o = dp_q;
  assign imm_o     = imm_q;
  assign sel_o     = sel_q;
  assign inv_o     = inv_q;
  assign dvec_o    = dvec_q;
  assign vl_cap_o  = vl_q;
  assign vl_o      = vl_res_q;
endmodule

// File: rtl/vcmp_ddff.sv
module vcmp_ddff
  import vcmp_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int NREGS = 8,
  parameter int NCR   = 8,
  parameter int MAXVL = 15,
  parameter int IMMW  = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(NCR),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rf_we_i,
  input  logic [AW-1:0]   rf_waddr_i,
  input  logic [XLEN-1:0] rf_wdata_i,
  input  logic            start_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [AW-1:0]   src_base_i,
  input  logic [CW-1:0]   dst_base_i,
  input  logic            src_vec_i,
  input  logic            dst_vec_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            incl_i,
  input  logic [1:0]      test_sel_i,
  input  logic            test_inv_i,
  output logic            cr_we_o,
  output logic [CW-1:0]   cr_idx_o,
  output logic [2:0]      cr_field_o,
  output logic            done_o,
  output logic [VLW-1:0]  vl_o
);
  logic [AW-1:0]   src_ptr;
  logic [XLEN-1:0] src_data;
  logic [IMMW-1:0] run_imm;
  logic [1:0]      run_sel;
  logic            run_inv;
  logic            run_dvec;
  logic [VLW-1:0]  run_vl;
  logic            run;
  logic            fail;
  cr_field_t       field;

  vcmp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_i),
    .waddr_i (rf_waddr_i),
    .wdata_i (rf_wdata_i),
    .raddr_i (src_ptr),
    .rdata_o (src_data)
  );

  vcmp_compare #(.XLEN(XLEN), .IMMW(IMMW)) u_cmp (
    .src_i   (src_data),
    .imm_i   (run_imm),
    .sel_i   (run_sel),
    .inv_i   (run_inv),
    .field_o (field),
    .fail_o  (fail)
  );

  vcmp_seq #(.AW(AW), .CW(CW), .VLW(VLW), .IMMW(IMMW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .vl_i       (vl_i),
    .src_base_i (src_base_i),
    .dst_base_i (dst_base_i),
    .src_vec_i  (src_vec_i),
    .dst_vec_i  (dst_vec_i),
    .imm_i      (imm_i),
    .incl_i     (incl_i),
    .sel_i      (test_sel_i),
    .inv_i      (test_inv_i),
    .fail_i     (fail),
    .run_o      (run),
    .done_o     (done_o),
    .src_ptr_o  (src_ptr),
    .dst_ptr_o  (cr_idx_o),
    .imm_o      (run_imm),
    .sel_o      (run_sel),
    .inv_o      (run_inv),
    .dvec_o     (run_dvec),
    .vl_cap_o   (run_vl),
    .vl_o       (vl_o)
  );

  assign cr_we_o    = run;
  assign cr_field_o = field;
endmodule

// File: rtl/vcmp_ddff_chk.sv
module vcmp_ddff_chk #(
  parameter int CW  = 3,
  parameter int VLW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           cr_we_o,
  input logic [CW-1:0]  cr_idx_o,
  input logic [2:0]     cr_field_o,
  input logic           done_o,
  input logic [VLW-1:0] vl_o,
  input logic           run_dvec,
  input logic [VLW-1:0] run_vl
);
  // R2
  field_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> $countones(cr_field_o) == 1);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cr_we_o);

  // R9
  done_after_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cr_we_o || start_i));

  // R3
  dst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_o && $past(cr_we_o) && run_dvec) |-> cr_idx_o == $past(cr_idx_o) + CW'(1));

  // R3
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_o && $past(cr_we_o) && !run_dvec) |-> $stable(cr_idx_o));

  // R8
  vl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vl_o <= run_vl);
endmodule

bind vcmp_ddff vcmp_ddff_chk #(.CW(CW), .VLW(VLW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cr_we_o    (cr_we_o),
  .cr_idx_o   (cr_idx_o),
  .cr_field_o (cr_field_o),
  .done_o     (done_o),
  .vl_o       (vl_o),
  .run_dvec   (run_dvec),
  .run_vl     (run_vl)
);

// File: tb/vcmp_ddff_tb.sv
`timescale 1ns/1ps
module vcmp_ddff_tb_top;
  localparam int XLEN = 16, NREGS = 8, NCR = 8, IMMW = 8;
  localparam int AW = 3, CW = 3, VLW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            rf_we_i = 1'b0;
  logic [AW-1:0]   rf_waddr_i = '0;
  logic [XLEN-1:0] rf_wdata_i = '0;
  logic            start_i = 1'b0;
  logic [VLW-1:0]  vl_i = '0;
  logic [AW-1:0]   src_base_i = '0;
  logic [CW-1:0]   dst_base_i = '0;
  logic            src_vec_i = 1'b0, dst_vec_i = 1'b0;
  logic [IMMW-1:0] imm_i = '0;
  logic            incl_i = 1'b0;
  logic [1:0]      test_sel_i = '0;
  logic            test_inv_i = 1'b0;
  logic            cr_we_o;
  logic [CW-1:0]   cr_idx_o;
  logic [2:0]      cr_field_o;
  logic            done_o;
  logic [VLW-1:0]  vl_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic signed [XLEN-1:0] rf_m [NREGS];

  always #2 clk_i = ~clk_i;

  vcmp_ddff dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] fexp(input logic signed [XLEN-1:0] a, input logic [IMMW-1:0] imm);
    logic signed [XLEN-1:0] b;
    b = XLEN'($signed(imm));
    return {a < b, a > b, a == b};
  endfunction

  function automatic bit fails(input logic [2:0] f, input logic [1:0] sel, input bit inv);
    if (sel == 2'd3) return 1'b0;
    return f[sel] ^ inv;
  endfunction

  task automatic rf_write(input int a, input int v);
    rf_we_i = 1'b1; rf_waddr_i = AW'(a); rf_wdata_i = XLEN'(v);
    @(negedge clk_i);
    rf_we_i = 1'b0;
    rf_m[a] = XLEN'(v);
  endtask

  task automatic run(input int vl, input int sb, input int db, input bit sv, input bit dv,
                     input int imm, input bit incl, input int sel, input bit inv, input bit poke);
    int exp_vl = vl;
    vl_i = VLW'(vl); src_base_i = AW'(sb); dst_base_i = CW'(db);
    src_vec_i = sv; dst_vec_i = dv; imm_i = IMMW'(imm);
    incl_i = incl; test_sel_i = 2'(sel); test_inv_i = inv;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = poke;
    for (int k = 0; k < vl; k++) begin
      int s = (sb + (sv ? k : 0)) % NREGS;
      int d = (db + (dv ? k : 0)) % NCR;
      logic [2:0] f = fexp(rf_m[s], IMMW'(imm));
      bit bad = fails(f, 2'(sel), inv);
      // R2 R4 field value, R3 slot, R10 held start leaves stream intact
      chk(cr_we_o === 1'b1, "R2", int'(cr_we_o), 1);
      chk(cr_field_o === f, "R4", int'(cr_field_o), int'(f));
      chk(cr_idx_o === CW'(d), "R3", int'(cr_idx_o), d);
      @(negedge clk_i);
      if (bad) begin
        exp_vl = incl ? k + 1 : k;
        break;
      end
    end
    // R5 R6 R7 R8 result; R9 pulse timing
    chk(done_o === 1'b1 && cr_we_o === 1'b0, "R9", int'(done_o), 1);
    chk(vl_o === VLW'(exp_vl), incl ? "R6" : "R7", int'(vl_o), exp_vl);
    start_i = 1'b0;
    @(negedge clk_i);
    // R10 no restart from a start held through the run
    chk(done_o === 1'b0 && cr_we_o === 1'b0, "R10", int'({done_o, cr_we_o}), 0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_up();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < NREGS; k++) rf_m[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cr_we_o === 1'b0 && done_o === 1'b0 && vl_o === '0, "R1", int'({cr_we_o, done_o, vl_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cr_we_o === 1'b0 && done_o === 1'b0, "R1", int'({cr_we_o, done_o}), 0);

    // R11 write then read back through compare
    rf_write(5, -3);
    run(1, 5, 2, 1, 1, -3, 1, 0, 0, 0);
    for (int k = 0; k < NREGS; k++) rf_write(k, k - 3);

    // R9 zero length
    run(0, 0, 0, 1, 1, 0, 1, 0, 0, 0);
    // R7 exclusive fail on element 0 -> 0
    run(4, 3, 1, 1, 1, 0, 0, 0, 0, 0);
    // R6 inclusive fail on element 0 -> 1
    run(4, 3, 1, 1, 1, 0, 1, 0, 0, 0);
    // R8 no failure, sel=3 (R5 no test), wraps indices
    run(8, 6, 5, 1, 1, 0, 1, 3, 1, 0);
    // R5 inverted less-than: fails when not below imm
    run(8, 0, 0, 1, 1, 1, 0, 2, 1, 0);
    // R5 greater-than test at element 5
    run(8, 0, 4, 1, 0, 1, 1, 1, 0, 0);
    // R4 scalar source, vector dest; R10 start held
    run(6, 2, 7, 0, 1, 5, 0, 0, 0, 1);
    // R3 scalar dest
    run(5, 1, 3, 1, 0, 9, 1, 0, 0, 1);

    for (int t = 0; t < 60; t++) begin
      if (t % 10 == 0) for (int k = 0; k < NREGS; k++) rf_write(k, int'($urandom_range(8)) - 4);
      run(int'($urandom_range(15)), int'($urandom_range(7)), int'($urandom_range(7)),
          1'($urandom), 1'($urandom), int'($urandom_range(8)) - 4, 1'($urandom),
          int'($urandom_range(3)), 1'($urandom), 1'($urandom));
    end
    finish_up();
  end
endmodule